// File: doc/BRIEF.md
# Diagnostic Buffer-Memory Window

This block gives a host register interface an indirect path into the buffer SRAM for diagnostics. The host writes a word address into two address registers: a 16-bit low part and an upper register that holds a 4-bit high part and a target-select bit. The host then reads or writes a data register. The block turns those data-register accesses into single-word SRAM cycles. It advances the low address after each completed transfer, so that consecutive words can be streamed.

SRAM reads take a variable number of cycles, so a data-register read never stalls the host bus. The first read starts a background fetch and answers with retry. The host reissues the read, and the block keeps answering retry until the fetched word has arrived. The next reissued read then returns that word. The window opens only while the controller is stopped, or suspended without the fast-suspend option. In any other mode, or when the target-select bit points at flash, data-register accesses complete at once with an all-ones pattern and never touch the SRAM.

The fetch controller has four states:
- IDLE: no fetch is pending.
- FETCH: a read has been issued and the word has not yet returned.
- READY: the fetched word is held.
- DRAIN: an in-flight fetch was cancelled and its late return is being waited out.

Its transitions are:
- IDLE to FETCH on a data read.
- FETCH to READY on SRAM return.
- FETCH to DRAIN on an address write while the fetch is in flight.
- FETCH to IDLE on an address write in the same cycle as the return.
- READY to IDLE on a data read, a data write or an address write.
- DRAIN to IDLE on SRAM return.

Top module: `diag_sram_port`

## Requirements
- R1: Register select 2'b00 is the 16-bit low address register. Select 2'b01 is the upper register: bits [3:0] are the high address and bit 15 is the flash-select bit, and all other bits read as 0. Both registers reset to zero and read back what was written.
- R2: Every SRAM cycle moves one 16-bit word at the 20-bit word address {high, low}.
- R3: A permitted data read with no fetched word held answers retry and issues exactly one SRAM read.
- R4: Reissued data reads answer retry until the fetched word has returned. The next read then acks with that word.
- R5: Each completed data read or write increments the low address by one. The low address wraps from FFFF to 0000 and the high address is left unchanged.
- R6: A permitted data write in IDLE or READY acks and issues one SRAM write of the host word. A data write while a fetch is in flight answers retry.
- R7: Data access is permitted only when stopped=1, or when suspended=1 with fast-suspend=0. Otherwise a data access acks with FFFF, issues no SRAM cycle and leaves the address unchanged.
- R8: With the flash-select bit set to 1, data accesses behave as in R7 (FFFF, no SRAM cycle).
- R9: Writing either address register discards any held or in-flight fetched word. The next read retries and fetches from the new address.
- R10: Ack and retry are never asserted together. Select 2'b11 acks with data 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host access strobe, one cycle per attempt |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_sel | input | 2 | Register select |
| host_wdata | input | 16 | Host write data |
| host_ack | output | 1 | Access completed this cycle |
| host_retry | output | 1 | Access must be reissued |
| host_rdata | output | 16 | Read data, valid with ack |
| ctl_stopped | input | 1 | Controller stopped |
| ctl_suspended | input | 1 | Controller suspended |
| ctl_fast_susp | input | 1 | Fast-suspend option active |
| sram_req | output | 1 | SRAM cycle strobe |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 20 | SRAM word address |
| sram_wdata | output | 16 | SRAM write word |
| sram_rvalid | input | 1 | SRAM read word returned |
| sram_rdata | input | 16 | SRAM read word |

## Verification
The bench cancels a fetch in two ways. In the first, the address is rewritten after the word has arrived. In the second, it is rewritten while the SRAM read is still in flight. A design that mishandled either case would hand back the stale word from the old address, or would latch the late return as though it were fresh.

The bench also drives a data write during a pending fetch and a read at low address FFFF. A wrong design would either clobber the SRAM bus or carry the wrap into the high address.

Gating is checked in three modes, and with the flash-select bit set. The bench counts SRAM strobes to confirm that a blocked access leaves the memory untouched and the address unchanged.

// File: rtl/diag_sram_pkg.sv
package diag_sram_pkg;
    typedef enum logic [1:0] {
        SEL_ADDR_LO = 2'b00,
        SEL_ADDR_HI = 2'b01,
        SEL_DATA    = 2'b10,
        SEL_RSVD    = 2'b11
    } diag_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_READY,
        ST_DRAIN
    } fetch_state_e;
endpackage

// File: rtl/diag_addr_regs.sv
module diag_addr_regs #(
    parameter int LO_W = 16,
    parameter int HI_W = 4,
    parameter int DATA_W = 16,
    parameter int FLASH_BIT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              inc,
    output logic [LO_W-1:0]   lo,
    output logic [HI_W-1:0]   hi,
    output logic              flash
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo    <= '0;
            hi    <= '0;
            flash <= 1'b0;
        end else begin
            if (wr_lo)
                lo <= wdata[LO_W-1:0];
            else if (inc)
                lo <= lo + 1'b1;
            if (wr_hi) begin
                hi    <= wdata[HI_W-1:0];
                flash <= wdata[FLASH_BIT];
            end
        end
    end

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_lo && !wr_hi) |=> (lo == LO_W'($past(lo) + 1'b1)) && $stable(hi));
endmodule

// File: rtl/diag_fetch_fsm.sv
module diag_fetch_fsm
    import diag_sram_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int AW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic              wr_go,
    input  logic              addr_wr,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sram_rvalid,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic              rsp_ack,
    output logic              rsp_retry,
    output logic [DATA_W-1:0] rsp_data,
    output logic              addr_inc,
    output logic              sram_req,
    output logic              sram_we,
    output logic [AW-1:0]     sram_addr,
    output logic [DATA_W-1:0] sram_wdata
);
    fetch_state_e state_q, state_d;
    logic [DATA_W-1:0] hold_q;
    logic issue_rd, issue_wr;

    assign issue_rd = rd_go && (state_q == ST_IDLE);
    assign issue_wr = wr_go && ((state_q == ST_IDLE) || (state_q == ST_READY));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rd_go) state_d = ST_FETCH;
            ST_FETCH: begin
                if (addr_wr)          state_d = sram_rvalid ? ST_IDLE : ST_DRAIN;
                else if (sram_rvalid) state_d = ST_READY;
            end
            ST_READY: if (rd_go || wr_go || addr_wr) state_d = ST_IDLE;
            ST_DRAIN: if (sram_rvalid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rsp_ack   = 1'b0;
        rsp_retry = 1'b0;
        rsp_data  = '0;
        addr_inc  = 1'b0;
        if (rd_go) begin
            if (state_q == ST_READY) begin
                rsp_ack  = 1'b1;
                rsp_data = hold_q;
                addr_inc = 1'b1;
            end else begin
                rsp_retry = 1'b1;
            end
        end else if (wr_go) begin
            if (issue_wr) begin
                rsp_ack  = 1'b1;
                addr_inc = 1'b1;
            end else begin
                rsp_retry = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sram_req   <= 1'b0;
            sram_we    <= 1'b0;
            sram_addr  <= '0;
            sram_wdata <= '0;
            hold_q     <= '0;
        end else begin
            sram_req <= issue_rd || issue_wr;
            sram_we  <= issue_wr;
            if (issue_rd || issue_wr) begin
                sram_addr  <= addr;
                sram_wdata <= wdata;
            end
            if (state_q == ST_FETCH && sram_rvalid && !addr_wr)
                hold_q <= sram_rdata;
        end
    end

    // R3
    first_read_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && state_q == ST_IDLE) |-> rsp_retry ##1 (sram_req && !sram_we));
    // R9
    discard_on_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr |=> (state_q != ST_READY));
    // R6
    busy_write_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && (state_q == ST_FETCH || state_q == ST_DRAIN)) |=> !sram_req);
endmodule

// File: rtl/diag_sram_port.sv
module diag_sram_port
    import diag_sram_pkg::*;
#(
    parameter int LO_W = 16,
    parameter int HI_W = 4,
    parameter int DATA_W = 16,
    parameter int FLASH_BIT = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_req,
    input  logic                 host_wr,
    input  logic [1:0]           host_sel,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic                 host_ack,
    output logic                 host_retry,
    output logic [DATA_W-1:0]    host_rdata,
    input  logic                 ctl_stopped,
    input  logic                 ctl_suspended,
    input  logic                 ctl_fast_susp,
    output logic                 sram_req,
    output logic                 sram_we,
    output logic [LO_W+HI_W-1:0] sram_addr,
    output logic [DATA_W-1:0]    sram_wdata,
    input  logic                 sram_rvalid,
    input  logic [DATA_W-1:0]    sram_rdata
);
    localparam int AW = LO_W + HI_W;
    localparam logic [DATA_W-1:0] BLOCKED_WORD = '1;

    logic [LO_W-1:0] lo;
    logic [HI_W-1:0] hi;
    logic flash, access_ok, data_sel, blocked, rd_go, wr_go;
    logic wr_lo, wr_hi, addr_wr, addr_inc;
    logic fsm_ack, fsm_retry;
    logic [DATA_W-1:0] fsm_data, hi_view;

    assign access_ok = ctl_stopped || (ctl_suspended && !ctl_fast_susp);
    assign data_sel  = host_req && (host_sel == SEL_DATA);
    assign blocked   = data_sel && (!access_ok || flash);
    assign rd_go     = data_sel && !blocked && !host_wr;
    assign wr_go     = data_sel && !blocked && host_wr;
    assign wr_lo     = host_req && host_wr && (host_sel == SEL_ADDR_LO);
    assign wr_hi     = host_req && host_wr && (host_sel == SEL_ADDR_HI);
    assign addr_wr   = wr_lo || wr_hi;

    diag_addr_regs #(.LO_W(LO_W), .HI_W(HI_W), .DATA_W(DATA_W), .FLASH_BIT(FLASH_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(host_wdata),
        .inc(addr_inc), .lo(lo), .hi(hi), .flash(flash)
    );

    diag_fetch_fsm #(.DATA_W(DATA_W), .AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .wr_go(wr_go), .addr_wr(addr_wr),
        .addr({hi, lo}), .wdata(host_wdata), .sram_rvalid(sram_rvalid),
        .sram_rdata(sram_rdata), .rsp_ack(fsm_ack), .rsp_retry(fsm_retry),
        .rsp_data(fsm_data), .addr_inc(addr_inc), .sram_req(sram_req),
        .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata)
    );

    always_comb begin
        hi_view = '0;
        hi_view[HI_W-1:0] = hi;
        hi_view[FLASH_BIT] = flash;
    end

    always_comb begin
        host_ack   = 1'b0;
        host_retry = 1'b0;
        host_rdata = '0;
        if (host_req) begin
            unique case (host_sel)
                SEL_ADDR_LO: begin host_ack = 1'b1; host_rdata = DATA_W'(lo); end
                SEL_ADDR_HI: begin host_ack = 1'b1; host_rdata = hi_view; end
                SEL_DATA: begin
                    if (blocked) begin
                        host_ack   = 1'b1;
                        host_rdata = BLOCKED_WORD;
                    end else begin
                        host_ack   = fsm_ack;
                        host_retry = fsm_retry;
                        host_rdata = fsm_data;
                    end
                end
                default: host_ack = 1'b1;
            endcase
        end
    end

    // R10
    ack_retry_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_ack && host_retry));
    // R7
    blocked_no_sram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_sel && !access_ok) |=> !sram_req);
    // R8
    flash_no_sram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_sel && flash) |=> !sram_req);
    // R7
    blocked_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> $stable(lo));
endmodule

// File: tb/tb_diag_sram_port.sv
module tb_diag_sram_port;
    logic clk = 0;
    logic rst_n = 0;
    logic host_req = 0, host_wr = 0;
    logic [1:0] host_sel = 0;
    logic [15:0] host_wdata = 0;
    logic host_ack, host_retry;
    logic [15:0] host_rdata;
    logic ctl_stopped = 1, ctl_suspended = 0, ctl_fast_susp = 0;
    logic sram_req, sram_we;
    logic [19:0] sram_addr;
    logic [15:0] sram_wdata;
    logic sram_rvalid = 0;
    logic [15:0] sram_rdata = 0;

    int n_chk = 0, n_fail = 0;
    int req_cnt = 0;
    logic [19:0] last_addr = 0;
    logic [15:0] mem [0:255];
    int lat_cnt = 0;
    logic [7:0] pend_idx = 0;

    always #2 clk = ~clk;

    diag_sram_port dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_retry(host_retry), .host_rdata(host_rdata), .ctl_stopped(ctl_stopped),
        .ctl_suspended(ctl_suspended), .ctl_fast_susp(ctl_fast_susp),
        .sram_req(sram_req), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rvalid(sram_rvalid), .sram_rdata(sram_rdata)
    );

    initial for (int i = 0; i < 256; i++) mem[i] = 16'hA500 ^ 16'(i * 37);

    // SRAM model: reads return after three cycles
    always @(posedge clk) begin
        sram_rvalid <= 1'b0;
        if (lat_cnt > 0) begin
            lat_cnt <= lat_cnt - 1;
            if (lat_cnt == 1) begin
                sram_rvalid <= 1'b1;
                sram_rdata  <= mem[pend_idx];
            end
        end
        if (sram_req) begin
            req_cnt   <= req_cnt + 1;
            last_addr <= sram_addr;
            if (sram_we) mem[sram_addr[7:0]] <= sram_wdata;
            else begin
                pend_idx <= sram_addr[7:0];
                lat_cnt  <= 3;
            end
        end
    end

    function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    task automatic acc(input logic [1:0] sel, input logic wr, input logic [15:0] wd,
                       output logic a, output logic r, output logic [15:0] d);
        @(negedge clk);
        host_req = 1; host_sel = sel; host_wr = wr; host_wdata = wd;
        #1;
        a = host_ack; r = host_retry; d = host_rdata;
        @(posedge clk); #1;
        host_req = 0; host_wr = 0;
    endtask

    task automatic wreg(input logic [1:0] sel, input logic [15:0] v);
        logic a, r; logic [15:0] d;
        acc(sel, 1, v, a, r, d);
    endtask

    task automatic rreg(input logic [1:0] sel, output logic [15:0] v);
        logic a, r;
        acc(sel, 0, 0, a, r, v);
    endtask

    task automatic read_word(output logic first_retry, output logic [15:0] data);
        logic a, r; logic [15:0] d;
        first_retry = 0; data = 16'hDEAD;
        for (int i = 0; i < 30; i++) begin
            acc(2'b10, 0, 0, a, r, d);
            if (i == 0) first_retry = r && !a;
            if (a) begin data = d; break; end
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rreg(2'b00, v); chk("R1 reset low", v, 0);
        rreg(2'b01, v); chk("R1 reset upper", v, 0);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        wreg(2'b00, 16'h1234); rreg(2'b00, v); chk("R1 low readback", v, 16'h1234);
        wreg(2'b01, 16'hFFFF); rreg(2'b01, v); chk("R1 upper readback", v, 16'h800F);
        wreg(2'b01, 16'h0000);
    endtask

    task automatic t_read();
        logic fr; logic [15:0] d, v;
        wreg(2'b00, 16'h0010);
        read_word(fr, d);
        chk("R3 first read retry", fr, 1);
        chk("R4 read data", d, mem[8'h10]);
        chk("R2 sram address", last_addr, 20'h00010);
        rreg(2'b00, v); chk("R5 increment after read", v, 16'h0011);
        wreg(2'b01, 16'h0003); wreg(2'b00, 16'h0005);
        read_word(fr, d);
        chk("R2 upper address used", last_addr, 20'h30005);
        chk("R4 data with upper", d, mem[8'h05]);
        wreg(2'b01, 16'h0000);
    endtask

    task automatic t_write();
        logic a, r; logic [15:0] d, v; logic fr;
        wreg(2'b00, 16'h0020);
        acc(2'b10, 1, 16'hBEEF, a, r, d);
        chk("R6 write ack", {a, r}, 2'b10);
        repeat (2) @(posedge clk); #1;
        chk("R6 sram written", mem[8'h20], 16'hBEEF);
        rreg(2'b00, v); chk("R5 increment after write", v, 16'h0021);
        acc(2'b10, 0, 0, a, r, d);
        acc(2'b10, 1, 16'h1111, a, r, d);
        chk("R6 write during fetch retries", {a, r}, 2'b01);
        read_word(fr, d);
        chk("R6 fetch completes after retried write", d, mem[8'h21]);
    endtask

    task automatic t_gate();
        logic a, r, fr; logic [15:0] d, v; int c0;
        wreg(2'b00, 16'h0040);
        ctl_stopped = 0; ctl_suspended = 0; ctl_fast_susp = 0;
        c0 = req_cnt;
        acc(2'b10, 0, 0, a, r, d);
        chk("R7 running read ack", {a, r}, 2'b10);
        chk("R7 running read ones", d, 16'hFFFF);
        ctl_suspended = 1; ctl_fast_susp = 1;
        acc(2'b10, 1, 16'h5555, a, r, d);
        chk("R7 fast suspend write ack", {a, r}, 2'b10);
        repeat (3) @(posedge clk); #1;
        chk("R7 no sram cycle", req_cnt, c0);
        rreg(2'b00, v); chk("R7 address unchanged", v, 16'h0040);
        ctl_fast_susp = 0;
        read_word(fr, d);
        chk("R7 plain suspend works", d, mem[8'h40]);
        ctl_stopped = 1; ctl_suspended = 0;
    endtask

    task automatic t_flash();
        logic a, r; logic [15:0] d, v; int c0;
        wreg(2'b01, 16'h8000); wreg(2'b00, 16'h0048);
        c0 = req_cnt;
        acc(2'b10, 0, 0, a, r, d);
        chk("R8 flash read ones", {15'b0, a, d}, {15'b0, 1'b1, 16'hFFFF});
        acc(2'b10, 1, 16'h0, a, r, d);
        repeat (3) @(posedge clk); #1;
        chk("R8 no sram cycle", req_cnt, c0);
        rreg(2'b00, v); chk("R8 address unchanged", v, 16'h0048);
        wreg(2'b01, 16'h0000);
    endtask

    task automatic t_discard();
        logic a, r, fr; logic [15:0] d;
        wreg(2'b00, 16'h0050);
        acc(2'b10, 0, 0, a, r, d);
        repeat (8) @(posedge clk);
        wreg(2'b00, 16'h0060);
        read_word(fr, d);
        chk("R9 held word discarded", fr, 1);
        chk("R9 new address fetched", d, mem[8'h60]);
        wreg(2'b00, 16'h0070);
        acc(2'b10, 0, 0, a, r, d);
        wreg(2'b00, 16'h0071);
        read_word(fr, d);
        chk("R9 in-flight discarded retry", fr, 1);
        chk("R9 in-flight new data", d, mem[8'h71]);
    endtask

    task automatic t_wrap();
        logic fr; logic [15:0] d, v;
        wreg(2'b01, 16'h0002); wreg(2'b00, 16'hFFFF);
        read_word(fr, d);
        rreg(2'b00, v); chk("R5 low wraps", v, 16'h0000);
        rreg(2'b01, v); chk("R5 upper unchanged", v, 16'h0002);
        wreg(2'b01, 16'h0000);
    endtask

    task automatic t_rsvd();
        logic a, r; logic [15:0] d;
        acc(2'b11, 0, 0, a, r, d);
        chk("R10 reserved ack", {a, r}, 2'b10);
        chk("R10 reserved data", d, 0);
    endtask

    function automatic void summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_regs();
        t_read();
        t_write();
        t_gate();
        t_flash();
        t_discard();
        t_wrap();
        t_rsvd();
        summary();
        $finish;
    end
endmodule